// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Read Engine

This block is the slave side of a two-wire (I2C) serial memory. It watches SCL and SDA for START, repeated START and STOP. It matches a 7-bit device address and then serves reads from a byte array. The byte array is a synchronous RAM that can be inferred as block RAM. A load port beside the bus fills it for testing.

The block keeps a single address pointer for reads and writes. The pointer always holds one past the last byte transferred and wraps from the top address to zero. There are three kinds of read:
- A read that uses the pointer as it stands.
- A random read. The master sends the word address in a write, abandons the write with a repeated START and then issues a read.
- A sequential read. The master acknowledges each byte and the block carries on through the array.

Written data bytes are stored at the pointer and move the pointer on. With `ADDR_W` = 13 the array holds 8192 bytes. The default of 10 keeps elaboration small.

SDA is open-drain: `sda_oe` high means the slave pulls the line low. Both bus inputs pass through a synchronizer. The system clock must therefore run well above SCL, so that each SCL low phase lasts at least four clock cycles.

Top module: `i2c_mem_rd_slave`

## Requirements
- R1: A START or repeated START (SDA falling while SCL is high) at any point discards the partial byte and returns the slave to device-address reception. The address pointer keeps its value.
- R2: A first byte whose upper 7 bits (MSB first) equal `DEV_ADDR` is acknowledged: the slave holds SDA low through the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R3: If the device address does not match, there is no acknowledge. SDA stays released, including through any following data clocks, until the next START.
- R4: After a matching read address, the slave sends the byte at the pointer. The pointer then holds that address plus one, so a plain read after an access to N returns byte N+1.
- R5: In a write, the two bytes after the device address are the word address, high byte first. Only the low `ADDR_W` bits are used and the upper bits are ignored. Once both bytes are acknowledged, the pointer is loaded with this address, even if a repeated START follows at once with no data.
- R6: After each byte it sends, the slave samples SDA on the rising edge of the ninth clock. Low (ACK) makes it send the next byte. High (NACK) makes it release SDA and stay silent until STOP or START.
- R7: The pointer wraps from 2**ADDR_W-1 to 0 on single and on sequential reads. Besides being loaded from a word address, the pointer only ever steps by +1.
- R8: Data bits go out MSB first. The slave changes SDA only while SCL is low.
- R9: Data bytes that follow the word address in a write are acknowledged. Each is stored at the pointer, and the pointer advances by one.
- R10: A high `bd_we` writes `bd_data` into the array at `bd_addr`. A later bus read returns that byte.
- R11: After reset, `sda_oe` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus) |
| sda_oe | output | 1 | High pulls SDA low |
| bd_we | input | 1 | Load port write strobe |
| bd_addr | input | ADDR_W | Load port byte address |
| bd_data | input | 8 | Load port byte value |

## Verification
The hardest situations to reach are the pointer wrap inside one long sequential read and the random read built from an abandoned write. The bench fills the whole array through the load port with an arithmetic pattern. It places the pointer four bytes below the top with a dummy write, then reads more than the full array in one transaction and checks every byte against the pattern at the address taken modulo the array size. A START is also placed three bits into a word-address byte to show that the pointer survives a broken transfer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WHI,
    PH_WLO,
    PH_WDAT,
    PH_SACK,
    PH_TX,
    PH_MACK
  } phase_t;
endpackage

// File: rtl/i2cm_line_sense.sv
module i2cm_line_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_val
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_in};
      sda_sh <= {sda_sh[TOP-1:0], sda_in};
      scl_q  <= scl_sh[TOP];
      sda_q  <= sda_sh[TOP];
    end
  end

  assign scl_now  = scl_sh[TOP];
  assign sda_val  = sda_sh[TOP];
  assign scl_rise = scl_now & ~scl_q;
  assign scl_fall = ~scl_now & scl_q;
  assign start_ev = scl_now & scl_q & sda_q & ~sda_val;
  assign stop_ev  = scl_now & scl_q & ~sda_q & sda_val;
endmodule

// File: rtl/i2cm_byte_ram.sv
module i2cm_byte_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cm_xfer_ctrl.sv
module i2cm_xfer_ctrl
  import i2cm_pkg::*;
#(
  parameter int          AW       = 10,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_val,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic [AW-1:0]     ptr,
  output logic              ptr_load,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output phase_t            phase
);
  localparam int HI_W = AW - BYTE_W;

  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitcnt;
  logic [HI_W-1:0]   hi_q;
  logic              mack;
  phase_t            after;

  always_ff @(posedge clk) begin
    ptr_load <= 1'b0;
    wr_en    <= 1'b0;
    if (rst) begin
      phase   <= PH_IDLE;
      after   <= PH_IDLE;
      sda_low <= 1'b0;
      ptr     <= '0;
      bitcnt  <= '0;
      shreg   <= '0;
      hi_q    <= '0;
      mack    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start_ev) begin
      phase   <= PH_DEV;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_ev) begin
      phase   <= PH_IDLE;
      sda_low <= 1'b0;
    end else begin
      case (phase)
        PH_DEV, PH_WHI, PH_WLO, PH_WDAT: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_val};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt  <= '0;
            sda_low <= 1'b1;
            phase   <= PH_SACK;
            case (phase)
              PH_DEV: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  after <= shreg[0] ? PH_TX : PH_WHI;
                end else begin
                  sda_low <= 1'b0;
                  phase   <= PH_IDLE;
                end
              end
              PH_WHI: begin
                hi_q  <= shreg[HI_W-1:0];
                after <= PH_WLO;
              end
              PH_WLO: begin
                ptr      <= {hi_q, shreg};
                ptr_load <= 1'b1;
                after    <= PH_WDAT;
              end
              default: begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
                after   <= PH_WDAT;
              end
            endcase
          end
        end
        PH_SACK: begin
          if (scl_fall) begin
            phase   <= after;
            bitcnt  <= '0;
            sda_low <= 1'b0;
            if (after == PH_TX) begin
              shreg   <= rd_data;
              sda_low <= ~rd_data[BYTE_W-1];
              bitcnt  <= 4'd1;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt != 4'd8) begin
              sda_low <= ~shreg[BYTE_W-2];
              shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt  <= bitcnt + 4'd1;
            end else begin
              sda_low <= 1'b0;
              ptr     <= ptr + 1'b1;
              phase   <= PH_MACK;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) mack <= ~sda_val;
          if (scl_fall) begin
            if (mack) begin
              shreg   <= rd_data;
              sda_low <= ~rd_data[BYTE_W-1];
              bitcnt  <= 4'd1;
              phase   <= PH_TX;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_rd_slave.sv
module i2c_mem_rd_slave
  import i2cm_pkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              bd_we,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic [7:0]        bd_data
);
  logic scl_rise, scl_fall, start_ev, stop_ev, sda_val;
  logic [BYTE_W-1:0] rd_data, ctl_wdata;
  logic [ADDR_W-1:0] ptr, ctl_waddr;
  logic ptr_load, ctl_we;
  phase_t phase;

  i2cm_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_val(sda_val)
  );

  i2cm_xfer_ctrl #(.AW(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_val(sda_val),
    .rd_data(rd_data), .sda_low(sda_oe),
    .ptr(ptr), .ptr_load(ptr_load),
    .wr_en(ctl_we), .wr_addr(ctl_waddr), .wr_data(ctl_wdata),
    .phase(phase)
  );

  i2cm_byte_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk(clk),
    .we(bd_we | ctl_we),
    .waddr(bd_we ? bd_addr : ctl_waddr),
    .wdata(bd_we ? bd_data : ctl_wdata),
    .raddr(ptr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          start_ev,
  input logic          ptr_load,
  input phase_t        phase,
  input logic [AW-1:0] ptr
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  a_r1_start_to_dev: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> phase == PH_DEV);

  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    phase == PH_IDLE |-> !sda_oe);

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (seen && !ptr_load && ptr != $past(ptr)) |-> ptr == $past(ptr) + 1'b1);

  a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    (seen && $rose(sda_oe)) |-> !scl_in);

  a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (!sda_oe && ptr == '0));
endmodule

bind i2c_mem_rd_slave i2cm_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .start_ev(start_ev), .ptr_load(ptr_load), .phase(phase), .ptr(ptr)
);

// File: tb/test_i2c_mem_rd_slave.sv
module test_i2c_mem_rd_slave;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [6:0] DEV = 7'h50;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  logic sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  int scl_hi_changes = 0;
  bit done = 0;

  assign sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_mem_rd_slave #(.ADDR_W(AW), .DEV_ADDR(DEV)) i_i2c_mem_rd_slave (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(((a * 29) + (a >> 4)) ^ 8'h3C);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    wt(1); m_sda = 1'b1; wt(H); scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop;
    wt(1); m_sda = 1'b0; wt(H); scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(logic b);
    wt(1); m_sda = b; wt(H - 1); scl = 1'b1; wt(H); scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wt(1); m_sda = 1'b1; wt(H - 1); scl = 1'b1; wt(2);
    b = sda_bus; wt(H - 2); scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack_low);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack_low);
  endtask

  task automatic recv_byte(logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  task automatic dev_read_hdr(string req);
    logic a;
    bus_start;
    send_byte({DEV, 1'b1}, a);
    check({req, " R2 read ack"}, a, 0);
  endtask

  task automatic read_cur(string req, int exp);
    logic [7:0] d;
    dev_read_hdr(req);
    recv_byte(1'b0, d);
    check(req, d, exp);
    bus_stop;
  endtask

  task automatic point_to(logic [7:0] hi, logic [7:0] lo);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a); check("R2 write ack", a, 0);
    send_byte(hi, a);          check("R5 hi ack", a, 0);
    send_byte(lo, a);          check("R5 lo ack", a, 0);
  endtask

  always @(negedge clk) begin
    logic prev_oe;
    if (!rst && scl && sda_oe != prev_oe) scl_hi_changes++;
    prev_oe = sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    wt(5);
    rst = 1'b0;
    wt(2);
    check("R11 oe after reset", sda_oe, 0);

    // R10: fill array through the load port
    for (int i = 0; i < DEPTH; i++) begin
      bd_we = 1'b1; bd_addr = AW'(i); bd_data = pat(i); wt(1);
    end
    bd_we = 1'b0;

    // R4 / R11: pointer starts at 0 and steps after each access
    read_cur("R11 R4 first read", pat(0));
    read_cur("R4 second read", pat(1));

    // R3: wrong device address, nothing driven
    bus_start;
    send_byte({7'h51, 1'b1}, a);
    check("R3 no ack", a, 1);
    recv_byte(1'b0, d);
    check("R3 line released", d, 8'hFF);
    bus_stop;
    read_cur("R3 pointer untouched", pat(2));

    // R5: random read, upper word-address bits ignored
    point_to(8'hFD, 8'h23);
    dev_read_hdr("R5");
    recv_byte(1'b0, d);
    check("R5 random read", d, pat(12'h123 & (DEPTH - 1)));
    bus_stop;
    read_cur("R4 after random", pat(12'h124 & (DEPTH - 1)));

    // R6 / R7: sequential read across the top of the array
    point_to(8'hFB, 8'hFC);
    dev_read_hdr("R6");
    for (int i = 0; i < DEPTH + 6; i++) begin
      recv_byte(i != DEPTH + 5, d);
      check("R6 R7 sequential byte", d, pat((1020 + i) % DEPTH));
    end
    wt(20);
    check("R6 released after nack", sda_oe, 0);
    bus_stop;
    read_cur("R7 pointer after long read", pat((1020 + DEPTH + 6) % DEPTH));

    // R7: single read of the top address wraps to 0
    point_to(8'h03, 8'hFF);
    dev_read_hdr("R7");
    recv_byte(1'b0, d);
    check("R7 top byte", d, pat(DEPTH - 1));
    bus_stop;
    read_cur("R7 wrap to zero", pat(0));

    // R9: write two bytes at 5, read them back in one transaction
    point_to(8'h00, 8'h05);
    send_byte(8'h5A, a); check("R9 data ack 1", a, 0);
    send_byte(8'hA5, a); check("R9 data ack 2", a, 0);
    bus_stop;
    point_to(8'h00, 8'h05);
    dev_read_hdr("R9");
    recv_byte(1'b1, d); check("R9 stored byte 1", d, 8'h5A);
    recv_byte(1'b0, d); check("R9 stored byte 2", d, 8'hA5);
    bus_stop;
    read_cur("R4 after write readback", pat(7));

    // R1: START three bits into the high word-address byte
    bus_start;
    send_byte({DEV, 1'b0}, a); check("R1 write ack", a, 0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    dev_read_hdr("R1");
    recv_byte(1'b0, d);
    check("R1 pointer kept across start", d, pat(8));
    bus_stop;

    // R6 / R8: sequential read continuing from the current pointer
    dev_read_hdr("R6 cur");
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d);
      check("R6 R8 current sequential", d, pat(9 + i));
    end
    bus_stop;

    // R10: load port overwrite seen by a bus read
    bd_we = 1'b1; bd_addr = AW'(12); bd_data = 8'hEE; wt(1); bd_we = 1'b0;
    read_cur("R10 load port byte", 8'hEE);

    check("R8 SDA changes while SCL high", scl_hi_changes, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule